// File: doc/BRIEF.md
# Clock and Reset Control Register Bank

This block is the software-visible control bank of a clock and reset domain. It keeps the settings for three PLLs, the routing controls that hand each PLL's output to the low-power domain, the top-level and memory-subsystem reset words, and a core-reset word. Each register has a fixed reset value and a set of reserved bits that cannot hold data. PLL lock is not modelled: the PLL status word returns a constant. Bits 3:0 of the core-reset word drive four per-core hold lines. A one-cycle restart pulse marks each core whose hold bit has just gone from 1 to 0.

There is one interrupt source. A hardware event input sets a status bit, and software clears that bit by writing 1 to it. A mask bit gates the interrupt line. Software cannot write the mask directly. It changes only through two command words: one clears the mask bits written as 1, the other sets them. The bus side is a plain word-wide port with byte enables. Only full 32-bit accesses to known offsets are accepted. Any other access does nothing and raises an error flag for one cycle.

Top module: `clkrst_regbank`

## Requirements
- R1: After reset, reads return these values at these byte offsets: 0x00 status 0, 0x04 mask 1, 0x08 and 0x0C 0, 0x10/0x14/0x18 PLL control 0x00012C09/0x00002C09/0x00012809, 0x1C PLL status 0x3F, 0x20/0x24/0x28 PLL-to-low-power control 0x400, 0x30 top reset 0x000F9FFE, 0x34 core reset 0x3D0F, 0x38 memory-subsystem reset 0x0C. After reset, irq is 0, core_hold is 4'hF and core_restart is 0.
- R2: Reserved bits read as 0 and ignore writes. The reserved masks are 0xF88C80F6 for the PLL control words, 0xC0FF for the low-power control words, 0xF06001 for top reset, 0xC2F0 for core reset and 0xF3 for memory reset. All other bits of those words can be written and read back. Because of bits 1:0 of its reserved mask, the memory reset word reads 0x0C out of reset.
- R3: The PLL status word at 0x1C always reads 0x3F, and writes to it are ignored.
- R4: A high irq_event sets status bit 0 at the next clock edge. Writing 1 to bit 0 at offset 0x00 clears it, and writing 0 leaves it unchanged. If an event and a clearing write fall in the same cycle, the bit ends up set.
- R5: irq is high exactly when status bit 0 is 1 and mask bit 0 is 0. It follows the registered state, so it changes in the cycle after the write or event that caused the change.
- R6: Writes to the mask at 0x04 are ignored. A write with bit 0 set at 0x08 clears mask bit 0, and a write with bit 0 set at 0x0C sets it. Both command offsets always read 0.
- R7: core_hold[i] equals bit i of the core-reset word (i = 0..3) and changes only when that word is written.
- R8: core_restart[i] pulses high for exactly one cycle after a core-reset write that changes bit i from 1 to 0. A bit that goes from 0 to 1, or that keeps its value, gives no pulse.
- R9: An access is bad if req_be is not 4'hF or if the offset is not listed in R1 (this includes offsets not a multiple of 4). A bad write changes nothing, a bad read returns 0, and both raise bus_err for the single cycle after the access.
- R10: rd_data is registered. It shows the value of a read in the cycle after the request and holds that value until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Access request this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte offset |
| req_be | input | 4 | Byte enables; only 4'hF is accepted |
| req_wdata | input | 32 | Write data |
| irq_event | input | 1 | Hardware event that sets status bit 0 |
| rd_data | output | 32 | Registered read data |
| bus_err | output | 1 | One-cycle flag for a rejected access |
| irq | output | 1 | Level interrupt |
| core_hold | output | 4 | Per-core hold-in-reset lines |
| core_restart | output | 4 | One-cycle restart pulse per core |

## Verification
The bench reads every word offset in the decode window, both out of reset and after all-ones writes. A decoder that aliases offsets, leaks reserved bits or gets a reset value wrong shows a mismatch at that offset. It steps the core-reset word through all sixteen values of its low nibble in sequence. A design that pulses on every write, on rising bits, or for more than one cycle gives restart values that differ from the computed old-and-not-new pattern. Interrupt sequences try a direct write to the mask, a zero write to the status bit, and an event in the same cycle as a clear. A design that lets the mask be written, treats the status bit as plain storage, or gives the clear priority over the event ends up with the wrong irq level.

// File: rtl/crb_pkg.sv
package crb_pkg;

  localparam int DW     = 32;
  localparam int NGEN   = 8;
  localparam int NCORE  = 4;
  localparam int IRQ_W  = 1;
  localparam int GIW    = $clog2(NGEN);

  localparam logic [7:0] OFF_STAT  = 8'h00;
  localparam logic [7:0] OFF_MASK  = 8'h04;
  localparam logic [7:0] OFF_EN    = 8'h08;
  localparam logic [7:0] OFF_DIS   = 8'h0C;
  localparam logic [7:0] OFF_PSTAT = 8'h1C;
  localparam logic [7:0] OFF_CORE  = 8'h34;

  localparam logic [DW-1:0] PSTAT_VAL = 32'h0000_003F;
  localparam logic [DW-1:0] CORE_RST  = 32'h0000_3D0F;
  localparam logic [DW-1:0] CORE_RSVD = 32'h0000_C2F0;

  typedef enum logic [2:0] {
    SEL_NONE, SEL_STAT, SEL_MASK, SEL_EN, SEL_DIS, SEL_PSTAT, SEL_GEN, SEL_CORE
  } sel_e;

  // plain storage words: 3 PLL controls, 3 low-power routing, top and memory reset
  function automatic logic [7:0] gen_off(input int i);
    case (i)
      0: gen_off = 8'h10;
      1: gen_off = 8'h14;
      2: gen_off = 8'h18;
      3: gen_off = 8'h20;
      4: gen_off = 8'h24;
      5: gen_off = 8'h28;
      6: gen_off = 8'h30;
      default: gen_off = 8'h38;
    endcase
  endfunction

  function automatic logic [DW-1:0] gen_rst(input int i);
    case (i)
      0: gen_rst = 32'h0001_2C09;
      1: gen_rst = 32'h0000_2C09;
      2: gen_rst = 32'h0001_2809;
      3, 4, 5: gen_rst = 32'h0000_0400;
      6: gen_rst = 32'h000F_9FFE;
      default: gen_rst = 32'h0000_000F;
    endcase
  endfunction

  function automatic logic [DW-1:0] gen_rsvd(input int i);
    case (i)
      0, 1, 2: gen_rsvd = 32'hF88C_80F6;
      3, 4, 5: gen_rsvd = 32'h0000_C0FF;
      6: gen_rsvd = 32'h00F0_6001;
      default: gen_rsvd = 32'h0000_00F3;
    endcase
  endfunction

endpackage

// File: rtl/crb_field_reg.sv
module crb_field_reg #(
  parameter int          W    = 32,
  parameter logic [31:0] RST  = '0,
  parameter logic [31:0] RSVD = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         we,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] q
);
  localparam logic [W-1:0] KEEP = ~RSVD[W-1:0];

  logic [W-1:0] q_next;

  always_comb begin
    q_next = q;
    if (we) q_next = wdata & KEEP;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= RST[W-1:0] & KEEP;
    else if (we) q <= q_next;
  end

  AST_RSVD_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !we |=> $stable(q)); // R2
endmodule

// File: rtl/crb_irq_ctrl.sv
module crb_irq_ctrl #(
  parameter int IW = 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [IW-1:0] event_i,
  input  logic          st_we,
  input  logic          en_we,
  input  logic          dis_we,
  input  logic [IW-1:0] wdata,
  output logic [IW-1:0] status_o,
  output logic [IW-1:0] mask_o,
  output logic          irq_o
);
  logic [IW-1:0] status_q, status_n;
  logic [IW-1:0] mask_q, mask_n;

  always_comb begin
    status_n = status_q;
    if (st_we) status_n = status_n & ~wdata;
    status_n = status_n | event_i;
    mask_n = mask_q;
    if (en_we)  mask_n = mask_n & ~wdata;
    if (dis_we) mask_n = mask_n | wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status_q <= '0;
      mask_q   <= '1;
    end else begin
      status_q <= status_n;
      if (en_we || dis_we) mask_q <= mask_n;
    end
  end

  assign irq_o    = |(status_q & ~mask_q);
  assign status_o = status_q;
  assign mask_o   = mask_q;

  AST_MASK_CMD_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    !(en_we || dis_we) |=> $stable(mask_q)); // R6
  AST_STATUS_SET_SRC: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(status_q[0]) |-> $past(event_i[0])); // R4
  AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (status_q == '0) |-> !irq_o); // R5
endmodule

// File: rtl/crb_core_rst.sv
module crb_core_rst #(
  parameter int          NC   = 4,
  parameter logic [31:0] RST  = 32'h3D0F,
  parameter logic [31:0] RSVD = 32'hC2F0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [31:0]   wdata,
  output logic [31:0]   q,
  output logic [NC-1:0] hold,
  output logic [NC-1:0] restart
);
  logic [31:0]   q_next;
  logic [NC-1:0] restart_n;

  always_comb begin
    q_next    = q;
    restart_n = '0;
    if (we) begin
      q_next    = wdata & ~RSVD;
      restart_n = q[NC-1:0] & ~q_next[NC-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q       <= RST & ~RSVD;
      restart <= '0;
    end else begin
      if (we) q <= q_next;
      restart <= restart_n;
    end
  end

  assign hold = q[NC-1:0];

  AST_RESTART_NEEDS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (restart != '0) |-> $past(we)); // R8
  AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    !we |=> $stable(hold)); // R7
endmodule

// File: rtl/clkrst_regbank.sv
module clkrst_regbank
  import crb_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [3:0]        req_be,
  input  logic [DW-1:0]     req_wdata,
  input  logic              irq_event,
  output logic [DW-1:0]     rd_data,
  output logic              bus_err,
  output logic              irq,
  output logic [NCORE-1:0]  core_hold,
  output logic [NCORE-1:0]  core_restart
);
  sel_e           sel;
  logic [GIW-1:0] gen_idx;
  logic           hit, wr_ok, rd_ok;
  logic [NGEN-1:0] gen_we;
  logic [DW-1:0]  gen_q [NGEN];
  logic [DW-1:0]  core_q;
  logic [IRQ_W-1:0] status, mask;
  logic [DW-1:0]  rd_next;
  logic           err_next;

  // address decode
  always_comb begin
    sel     = SEL_NONE;
    gen_idx = '0;
    if (req_be == 4'hF) begin
      if (req_addr == ADDR_W'(OFF_STAT))       sel = SEL_STAT;
      else if (req_addr == ADDR_W'(OFF_MASK))  sel = SEL_MASK;
      else if (req_addr == ADDR_W'(OFF_EN))    sel = SEL_EN;
      else if (req_addr == ADDR_W'(OFF_DIS))   sel = SEL_DIS;
      else if (req_addr == ADDR_W'(OFF_PSTAT)) sel = SEL_PSTAT;
      else if (req_addr == ADDR_W'(OFF_CORE))  sel = SEL_CORE;
      for (int i = 0; i < NGEN; i++) begin
        if (req_addr == ADDR_W'(gen_off(i))) begin
          sel     = SEL_GEN;
          gen_idx = GIW'(i);
        end
      end
    end
  end

  assign hit   = (sel != SEL_NONE);
  assign wr_ok = req_valid && req_write && hit;
  assign rd_ok = req_valid && !req_write;

  generate
    for (genvar g = 0; g < NGEN; g++) begin : g_word
      assign gen_we[g] = wr_ok && (sel == SEL_GEN) && (gen_idx == GIW'(g));
      crb_field_reg #(
        .W    (DW),
        .RST  (gen_rst(g)),
        .RSVD (gen_rsvd(g))
      ) u_word (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (gen_we[g]),
        .wdata (req_wdata),
        .q     (gen_q[g])
      );
    end
  endgenerate

  crb_irq_ctrl #(.IW(IRQ_W)) u_irq (
    .clk      (clk),
    .rst_n    (rst_n),
    .event_i  (irq_event),
    .st_we    (wr_ok && sel == SEL_STAT),
    .en_we    (wr_ok && sel == SEL_EN),
    .dis_we   (wr_ok && sel == SEL_DIS),
    .wdata    (req_wdata[IRQ_W-1:0]),
    .status_o (status),
    .mask_o   (mask),
    .irq_o    (irq)
  );

  crb_core_rst #(.NC(NCORE), .RST(CORE_RST), .RSVD(CORE_RSVD)) u_core (
    .clk     (clk),
    .rst_n   (rst_n),
    .we      (wr_ok && sel == SEL_CORE),
    .wdata   (req_wdata),
    .q       (core_q),
    .hold    (core_hold),
    .restart (core_restart)
  );

  // read mux and response registers
  always_comb begin
    rd_next  = rd_data;
    err_next = req_valid && !hit;
    if (rd_ok) begin
      case (sel)
        SEL_STAT:  rd_next = DW'(status);
        SEL_MASK:  rd_next = DW'(mask);
        SEL_PSTAT: rd_next = PSTAT_VAL;
        SEL_GEN:   rd_next = gen_q[gen_idx];
        SEL_CORE:  rd_next = core_q;
        default:   rd_next = '0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_data <= '0;
      bus_err <= 1'b0;
    end else begin
      if (rd_ok) rd_data <= rd_next;
      bus_err <= err_next;
    end
  end

  AST_ERR_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    bus_err |-> $past(req_valid && !hit)); // R9
  AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_ok |=> $stable(rd_data)); // R10
endmodule

// File: tb/clkrst_regbank_bench.sv
module clkrst_regbank_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid, req_write, irq_event;
  logic [7:0]  req_addr;
  logic [3:0]  req_be;
  logic [31:0] req_wdata;
  logic [31:0] rd_data;
  logic        bus_err, irq;
  logic [3:0]  core_hold, core_restart;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #4 clk = ~clk;

  clkrst_regbank #(.ADDR_W(8)) u_clkrst_regbank (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_be(req_be), .req_wdata(req_wdata),
    .irq_event(irq_event), .rd_data(rd_data), .bus_err(bus_err), .irq(irq),
    .core_hold(core_hold), .core_restart(core_restart)
  );

  function automatic bit mapped(input logic [7:0] a);
    case (a)
      8'h00, 8'h04, 8'h08, 8'h0C, 8'h10, 8'h14, 8'h18, 8'h1C,
      8'h20, 8'h24, 8'h28, 8'h30, 8'h34, 8'h38: mapped = 1;
      default: mapped = 0;
    endcase
  endfunction

  function automatic logic [31:0] rsvd_of(input logic [7:0] a);
    case (a)
      8'h10, 8'h14, 8'h18: rsvd_of = 32'hF88C80F6;
      8'h20, 8'h24, 8'h28: rsvd_of = 32'h0000C0FF;
      8'h30: rsvd_of = 32'h00F06001;
      8'h34: rsvd_of = 32'h0000C2F0;
      8'h38: rsvd_of = 32'h000000F3;
      default: rsvd_of = 32'hFFFFFFFF;
    endcase
  endfunction

  function automatic logic [31:0] rst_of(input logic [7:0] a);
    case (a)
      8'h04: rst_of = 32'h1;
      8'h10: rst_of = 32'h00012C09;
      8'h14: rst_of = 32'h00002C09;
      8'h18: rst_of = 32'h00012809;
      8'h1C: rst_of = 32'h3F;
      8'h20, 8'h24, 8'h28: rst_of = 32'h400;
      8'h30: rst_of = 32'h000F9FFE;
      8'h34: rst_of = 32'h3D0F;
      8'h38: rst_of = 32'h0C;
      default: rst_of = 32'h0;
    endcase
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic access(input bit wr, input logic [7:0] a, input logic [3:0] be,
                        input logic [31:0] d);
    @(negedge clk);
    req_valid = 1; req_write = wr; req_addr = a; req_be = be; req_wdata = d;
    @(negedge clk);
    req_valid = 0; req_write = 0;
  endtask

  task automatic rd(input logic [7:0] a);
    access(0, a, 4'hF, 32'h0);
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    access(1, a, 4'hF, d);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [3:0] prev;
    rst_n = 0; req_valid = 0; req_write = 0; req_addr = 0; req_be = 0;
    req_wdata = 0; irq_event = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // R1 reset state of outputs
    chk("R1 irq", {31'b0, irq}, 32'h0);
    chk("R1 core_hold", {28'b0, core_hold}, 32'hF);
    chk("R1 core_restart", {28'b0, core_restart}, 32'h0);

    // R1/R9 sweep of all word offsets out of reset
    for (int a = 0; a < 256; a += 4) begin
      rd(8'(a));
      chk($sformatf("R1 read %h", a), rd_data, rst_of(8'(a)));
      chk($sformatf("R9 err %h", a), {31'b0, bus_err}, {31'b0, !mapped(8'(a))});
    end

    // R2/R3/R9 all-ones writes to storage words, status word and holes
    for (int a = 16; a < 256; a += 4) begin
      wr(8'(a), 32'hFFFFFFFF);
      chk($sformatf("R9 wr err %h", a), {31'b0, bus_err}, {31'b0, !mapped(8'(a))});
      rd(8'(a));
      if (a == 8'h1C)
        chk("R3 pll status ro", rd_data, 32'h3F);
      else if (mapped(8'(a)))
        chk($sformatf("R2 ones %h", a), rd_data, ~rsvd_of(8'(a)));
      else
        chk($sformatf("R9 hole %h", a), rd_data, 32'h0);
    end

    // R9 sub-word write and misaligned read
    access(1, 8'h10, 4'h3, 32'h0);
    chk("R9 subword err", {31'b0, bus_err}, 32'h1);
    @(negedge clk);
    chk("R9 err one cycle", {31'b0, bus_err}, 32'h0);
    rd(8'h10);
    chk("R9 subword ignored", rd_data, ~rsvd_of(8'h10));
    rd(8'h11);
    chk("R9 misaligned read", rd_data, 32'h0);
    chk("R9 misaligned err", {31'b0, bus_err}, 32'h1);
    // R10 hold after an idle cycle and after a write
    wr(8'h14, 32'h0);
    chk("R10 rd_data held on write", rd_data, 32'h0);
    rd(8'h18);
    @(negedge clk);
    chk("R10 rd_data held idle", rd_data, ~rsvd_of(8'h18));

    // R7/R8 sweep over the core nibble; reg now holds 0xFFFF3D0F
    prev = 4'hF;
    for (int v = 0; v < 16; v++) begin
      wr(8'h34, 32'hFFFF3D00 | 32'(v));
      chk($sformatf("R7 hold %0d", v), {28'b0, core_hold}, 32'(v));
      chk($sformatf("R8 restart %0d", v), {28'b0, core_restart}, {28'b0, prev & ~4'(v)});
      @(negedge clk);
      chk($sformatf("R8 pulse width %0d", v), {28'b0, core_restart}, 32'h0);
      chk($sformatf("R7 hold idle %0d", v), {28'b0, core_hold}, 32'(v));
      prev = 4'(v);
    end
    wr(8'h34, 32'hFFFF3D0F);
    chk("R8 same value no pulse", {28'b0, core_restart}, 32'h0);
    wr(8'h34, 32'hFFFF3D0F);
    chk("R8 rewrite no pulse", {28'b0, core_restart}, 32'h0);

    // R4/R5/R6 interrupt path
    @(negedge clk); irq_event = 1;
    @(negedge clk); irq_event = 0;
    chk("R5 masked irq", {31'b0, irq}, 32'h0);
    rd(8'h00);
    chk("R4 status set", rd_data, 32'h1);
    wr(8'h04, 32'h0);
    rd(8'h04);
    chk("R6 mask direct write ignored", rd_data, 32'h1);
    wr(8'h08, 32'h1);
    chk("R5 irq after enable", {31'b0, irq}, 32'h1);
    rd(8'h08);
    chk("R6 enable reads 0", rd_data, 32'h0);
    rd(8'h04);
    chk("R6 mask cleared", rd_data, 32'h0);
    wr(8'h00, 32'h0);
    chk("R4 write 0 keeps status", {31'b0, irq}, 32'h1);
    wr(8'h0C, 32'h1);
    chk("R6 disable masks irq", {31'b0, irq}, 32'h0);
    rd(8'h0C);
    chk("R6 disable reads 0", rd_data, 32'h0);
    wr(8'h08, 32'h1);
    chk("R5 irq again", {31'b0, irq}, 32'h1);
    wr(8'h00, 32'h1);
    chk("R4 w1c clears", {31'b0, irq}, 32'h0);
    rd(8'h00);
    chk("R4 status read 0", rd_data, 32'h0);
    @(negedge clk);
    req_valid = 1; req_write = 1; req_addr = 8'h00; req_be = 4'hF;
    req_wdata = 32'h1; irq_event = 1;
    @(negedge clk);
    req_valid = 0; req_write = 0; irq_event = 0;
    chk("R4 event beats clear", {31'b0, irq}, 32'h1);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule